// File: doc/BRIEF.md
# Flash Segment Write-Lock Sequence Guard

This block sits in front of the write path of one flash segment. It sees every byte write aimed at that segment as an address and data pair. It recognises the short command sequences that turn the segment's software write lock on or off, and it keeps the lock state in one register bit. A card holds one instance per segment. Each instance is given its segment's position through parameters: whether it is the odd member of a pair, and which pair it belongs to.

While the segment is unlocked, every write goes through to the write path. A three-write sequence turns the lock on and also opens a data window. Writes inside that window go through until the page-load timer reports the end of loading; the lock then stays on. A six-write sequence turns the lock off. While the segment is locked and no window is open, writes are dropped. Each write produces a one-cycle accept or drop pulse. An accepted write is forwarded on a registered address and data pair.

Top module: `sdp_guard`

## Requirements
- R1: After reset the segment is unlocked (`protected_o`=0). `accept_o` and `drop_o` are 0, and no data window is open.
- R2: While unlocked, every write is accepted. In the cycle after the write, `accept_o`=1, `drop_o`=0, and `pass_addr_o`/`pass_data_o` carry that write's address and data.
- R3: The writes 0xAA to SEQ_A, 0x55 to SEQ_B and 0xA0 to SEQ_A, in that order, set `protected_o` in the cycle after the third write.
- R4: After the R3 sequence, writes are accepted, even ones that look like commands, until `load_end_i` is seen. A write in the same cycle as `load_end_i` is still accepted. Later writes are dropped, and `protected_o` stays 1.
- R5: While locked with no window open, a write gives `drop_o`=1 and `accept_o`=0, and `pass_addr_o`/`pass_data_o` keep their previous values.
- R6: The writes 0xAA@SEQ_A, 0x55@SEQ_B, 0x80@SEQ_A, 0xAA@SEQ_A, 0x55@SEQ_B and 0x20@SEQ_A, in that order, clear `protected_o` after the last write. When the sequence starts locked, all six writes are dropped.
- R7: A write that does not match the next expected step returns the matcher to idle. A later write that would have been the correct next step does not resume the sequence.
- R8: SEQ_A is 0x0AAAA + ODD_SEG and SEQ_B is 0x05554 + ODD_SEG. Address bit ADDR_W-1 equals HI_PAIR. The full address is compared, so a write with the wrong low bit or the wrong top bit does not match.
- R9: `load_end_i` has no effect when no data window is open. In particular, it does not reset a partly matched sequence.
- R10: Instances are independent. Writes to one segment do not change the lock state or the forwarding of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Byte write strobe for this segment |
| wr_addr_i | input | ADDR_W | Card byte address of the write |
| wr_data_i | input | 8 | Write data byte |
| load_end_i | input | 1 | Page-load timer reports end of loading |
| protected_o | output | 1 | Software write lock state |
| accept_o | output | 1 | Previous-cycle write was forwarded |
| drop_o | output | 1 | Previous-cycle write was blocked |
| pass_addr_o | output | ADDR_W | Address of the last forwarded write |
| pass_data_o | output | 8 | Data of the last forwarded write |

## Verification
A data write and the end-of-load signal can arrive in the same cycle while the window is open. The bench provokes this by asserting `load_end_i` together with a window write. It expects that write to be accepted, the next write to be dropped, and the lock to remain on. A second collision is between an isolated `load_end_i` pulse and a half-entered command sequence. The bench places the pulse between the first and second steps of the lock sequence, and judges the case by whether the lock still sets after the third step.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] K_AA = 8'hAA;
  localparam logic [BYTE_W-1:0] K_55 = 8'h55;
  localparam logic [BYTE_W-1:0] K_A0 = 8'hA0;
  localparam logic [BYTE_W-1:0] K_80 = 8'h80;
  localparam logic [BYTE_W-1:0] K_20 = 8'h20;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_AA_A,
    CMD_55_B,
    CMD_A0_A,
    CMD_80_A,
    CMD_20_A
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_U1,
    ST_U2,
    ST_L3,
    ST_L4,
    ST_L5,
    ST_OPEN
  } seq_st_e;
endpackage

// File: rtl/sdp_cmd_match.sv
module sdp_cmd_match
  import sdp_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter bit ODD_SEG = 1'b0,
  parameter bit HI_PAIR = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output cmd_e              cmd_o
);
  localparam logic [ADDR_W-1:0] TOP_BIT = ADDR_W'(HI_PAIR) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] SEQ_A   = ADDR_W'(32'h0AAAA | 32'(ODD_SEG)) | TOP_BIT;
  localparam logic [ADDR_W-1:0] SEQ_B   = ADDR_W'(32'h05554 | 32'(ODD_SEG)) | TOP_BIT;

  logic hit_a, hit_b;
  assign hit_a = (addr_i == SEQ_A);
  assign hit_b = (addr_i == SEQ_B);

  always_comb begin
    cmd_o = CMD_NONE;
    if (hit_a) begin
      unique case (data_i)
        K_AA:    cmd_o = CMD_AA_A;
        K_A0:    cmd_o = CMD_A0_A;
        K_80:    cmd_o = CMD_80_A;
        K_20:    cmd_o = CMD_20_A;
        default: cmd_o = CMD_NONE;
      endcase
    end else if (hit_b && data_i == K_55) begin
      cmd_o = CMD_55_B;
    end
  end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_valid_i,
  input  cmd_e cmd_i,
  input  logic load_end_i,
  output logic prot_o,
  output logic window_o
);
  seq_st_e st_q, st_d;
  logic    prot_q, prot_d;

  always_comb begin
    st_d   = st_q;
    prot_d = prot_q;
    unique case (st_q)
      ST_OPEN: if (load_end_i) st_d = ST_IDLE;
      ST_IDLE: if (wr_valid_i) st_d = (cmd_i == CMD_AA_A) ? ST_U1 : ST_IDLE;
      ST_U1:   if (wr_valid_i) st_d = (cmd_i == CMD_55_B) ? ST_U2 : ST_IDLE;
      ST_U2: begin
        if (wr_valid_i) begin
          if (cmd_i == CMD_A0_A) begin
            st_d   = ST_OPEN;
            prot_d = 1'b1;
          end else if (cmd_i == CMD_80_A) begin
            st_d = ST_L3;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_L3:   if (wr_valid_i) st_d = (cmd_i == CMD_AA_A) ? ST_L4 : ST_IDLE;
      ST_L4:   if (wr_valid_i) st_d = (cmd_i == CMD_55_B) ? ST_L5 : ST_IDLE;
      ST_L5: begin
        if (wr_valid_i) begin
          st_d = ST_IDLE;
          if (cmd_i == CMD_20_A) prot_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prot_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      prot_q <= prot_d;
    end
  end

  assign prot_o   = prot_q;
  assign window_o = (st_q == ST_OPEN);

  // R3
  prot_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_q) |-> $past(wr_valid_i && cmd_i == CMD_A0_A));
  // R6
  prot_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_q) |-> $past(wr_valid_i && cmd_i == CMD_20_A));
  // R4
  open_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OPEN) |-> prot_q);
  // R9
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(load_end_i && !wr_valid_i) && $past(st_q) != ST_OPEN) |-> $stable(st_q));
endmodule

// File: rtl/sdp_write_gate.sv
module sdp_write_gate
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              prot_i,
  input  logic              window_i,
  output logic              accept_o,
  output logic              drop_o,
  output logic [ADDR_W-1:0] pass_addr_o,
  output logic [BYTE_W-1:0] pass_data_o
);
  logic let_through;
  assign let_through = !prot_i || window_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o    <= 1'b0;
      drop_o      <= 1'b0;
      pass_addr_o <= '0;
      pass_data_o <= '0;
    end else begin
      accept_o <= wr_valid_i && let_through;
      drop_o   <= wr_valid_i && !let_through;
      if (wr_valid_i && let_through) begin
        pass_addr_o <= wr_addr_i;
        pass_data_o <= wr_data_i;
      end
    end
  end

  // R2
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || drop_o) |-> $past(wr_valid_i));
  // R2
  fwd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (pass_data_o == $past(wr_data_i) && pass_addr_o == $past(wr_addr_i)));
  // R5
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> ($stable(pass_data_o) && $stable(pass_addr_o)));
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
  import sdp_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter bit ODD_SEG = 1'b0,
  parameter bit HI_PAIR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              load_end_i,
  output logic              protected_o,
  output logic              accept_o,
  output logic              drop_o,
  output logic [ADDR_W-1:0] pass_addr_o,
  output logic [7:0]        pass_data_o
);
  cmd_e cmd;
  logic prot, window;

  sdp_cmd_match #(
    .ADDR_W (ADDR_W),
    .ODD_SEG(ODD_SEG),
    .HI_PAIR(HI_PAIR)
  ) u_match (
    .addr_i(wr_addr_i),
    .data_i(wr_data_i),
    .cmd_o (cmd)
  );

  sdp_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_valid_i(wr_valid_i),
    .cmd_i     (cmd),
    .load_end_i(load_end_i),
    .prot_o    (prot),
    .window_o  (window)
  );

  sdp_write_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .prot_i     (prot),
    .window_i   (window),
    .accept_o   (accept_o),
    .drop_o     (drop_o),
    .pass_addr_o(pass_addr_o),
    .pass_data_o(pass_data_o)
  );

  assign protected_o = prot;

  // R5
  no_pass_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_valid_i && prot && !window)) |-> (drop_o && !accept_o));
endmodule

// File: tb/sdp_guard_bench.sv
module sdp_guard_bench;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          v_a = 1'b0, v_b = 1'b0, lend = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;

  logic          prot_a, acc_a, drop_a, prot_b, acc_b, drop_b;
  logic [AW-1:0] paddr_a, paddr_b;
  logic [7:0]    pdata_a, pdata_b;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sdp_guard #(.ADDR_W(AW)) u_sdp_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(v_a), .wr_addr_i(addr), .wr_data_i(data),
    .load_end_i(lend), .protected_o(prot_a), .accept_o(acc_a), .drop_o(drop_a),
    .pass_addr_o(paddr_a), .pass_data_o(pdata_a));

  sdp_guard #(.ADDR_W(AW), .ODD_SEG(1'b1), .HI_PAIR(1'b1)) u_sdp_guard_odd (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(v_b), .wr_addr_i(addr), .wr_data_i(data),
    .load_end_i(lend), .protected_o(prot_b), .accept_o(acc_b), .drop_o(drop_b),
    .pass_addr_o(paddr_b), .pass_data_o(pdata_b));

  typedef struct packed {
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic          le;
    logic          acc;
    logic          prot;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{21'h00100, 8'h12, 1'b0, 1'b1, 1'b0},
    '{21'h0AAAA, 8'hAA, 1'b0, 1'b1, 1'b0},
    '{21'h05554, 8'h55, 1'b0, 1'b1, 1'b0},
    '{21'h0AAAA, 8'hA0, 1'b0, 1'b1, 1'b1},
    '{21'h00200, 8'h5A, 1'b0, 1'b1, 1'b1},
    '{21'h00201, 8'h5B, 1'b1, 1'b1, 1'b1},
    '{21'h00202, 8'h5C, 1'b0, 1'b0, 1'b1},
    '{21'h0AAAA, 8'hAA, 1'b0, 1'b0, 1'b1},
    '{21'h05555, 8'h55, 1'b0, 1'b0, 1'b1},
    '{21'h05554, 8'h55, 1'b0, 1'b0, 1'b1},
    '{21'h00300, 8'h66, 1'b0, 1'b0, 1'b1},
    '{21'h0AAAA, 8'hAA, 1'b0, 1'b0, 1'b1},
    '{21'h05554, 8'h55, 1'b0, 1'b0, 1'b1},
    '{21'h0AAAA, 8'h80, 1'b0, 1'b0, 1'b1},
    '{21'h0AAAA, 8'hAA, 1'b0, 1'b0, 1'b1},
    '{21'h05554, 8'h55, 1'b0, 1'b0, 1'b1},
    '{21'h0AAAA, 8'h20, 1'b0, 1'b0, 1'b0},
    '{21'h00400, 8'h44, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit odd, input logic [AW-1:0] a, input logic [7:0] d, input bit le);
    @(negedge clk);
    addr = a; data = d; lend = le;
    if (odd) v_b = 1'b1; else v_a = 1'b1;
    @(negedge clk);
    v_a = 1'b0; v_b = 1'b0; lend = 1'b0;
  endtask

  task automatic end_pulse();
    @(negedge clk); lend = 1'b1;
    @(negedge clk); lend = 1'b0;
  endtask

  task automatic out_a(input bit acc, input bit prot, input string req);
    chk(acc_a == acc && drop_a == !acc, req, {acc_a, drop_a}, {acc, !acc});
    chk(prot_a == prot, req, prot_a, prot);
  endtask

  task automatic out_b(input bit acc, input bit prot, input string req);
    chk(acc_b == acc && drop_b == !acc, req, {acc_b, drop_b}, {acc, !acc});
    chk(prot_b == prot, req, prot_b, prot);
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prot_a == 0 && acc_a == 0 && drop_a == 0, "R1 even", {prot_a, acc_a, drop_a}, 0);
    chk(prot_b == 0 && acc_b == 0 && drop_b == 0, "R1 odd", {prot_b, acc_b, drop_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prot_a == 0 && acc_a == 0, "R1 after release", {prot_a, acc_a}, 0);

    // R2 R3 R4 R5 R6 R7 table walk on the even segment
    for (int i = 0; i < 18; i++) begin
      wr(1'b0, VECS[i].a, VECS[i].d, VECS[i].le);
      out_a(VECS[i].acc, VECS[i].prot, $sformatf("R2 R3 R4 R5 R6 R7 vec %0d", i));
      if (VECS[i].acc)
        chk(pdata_a == VECS[i].d && paddr_a == VECS[i].a, "R2 forward",
            {pdata_a, paddr_a}, {VECS[i].d, VECS[i].a});
    end

    // R9: end pulse between first and second steps does not cancel the sequence
    wr(1'b0, 21'h0AAAA, 8'hAA, 1'b0); out_a(1'b1, 1'b0, "R9 step1");
    end_pulse();
    wr(1'b0, 21'h05554, 8'h55, 1'b0); out_a(1'b1, 1'b0, "R9 step2");
    wr(1'b0, 21'h0AAAA, 8'hA0, 1'b0); out_a(1'b1, 1'b1, "R9 lock set");

    // R4: window open, command-looking byte is data, closes on end pulse
    wr(1'b0, 21'h0AAAA, 8'hAA, 1'b0); out_a(1'b1, 1'b1, "R4 cmd as data");
    wr(1'b0, 21'h00500, 8'h77, 1'b0); out_a(1'b1, 1'b1, "R4 window write");
    end_pulse();
    chk(prot_a == 1, "R4 lock kept", prot_a, 1);
    wr(1'b0, 21'h00501, 8'h88, 1'b0); out_a(1'b0, 1'b1, "R4 closed");
    // R5 forwarding held
    chk(pdata_a == 8'h77 && paddr_a == 21'h00500, "R5 hold", {pdata_a, paddr_a}, {8'h77, 21'h00500});

    // R7: unlock with last step at wrong offset keeps lock
    wr(1'b0, 21'h0AAAA, 8'hAA, 1'b0);
    wr(1'b0, 21'h05554, 8'h55, 1'b0);
    wr(1'b0, 21'h0AAAA, 8'h80, 1'b0);
    wr(1'b0, 21'h0AAAA, 8'hAA, 1'b0);
    wr(1'b0, 21'h05554, 8'h55, 1'b0);
    wr(1'b0, 21'h05554, 8'h20, 1'b0); out_a(1'b0, 1'b1, "R7 bad final step");
    wr(1'b0, 21'h0AAAA, 8'h20, 1'b0); out_a(1'b0, 1'b1, "R7 no resume");

    // R6 full unlock
    wr(1'b0, 21'h0AAAA, 8'hAA, 1'b0); out_a(1'b0, 1'b1, "R6 s1");
    wr(1'b0, 21'h05554, 8'h55, 1'b0);
    wr(1'b0, 21'h0AAAA, 8'h80, 1'b0);
    wr(1'b0, 21'h0AAAA, 8'hAA, 1'b0);
    wr(1'b0, 21'h05554, 8'h55, 1'b0); out_a(1'b0, 1'b1, "R6 s5");
    wr(1'b0, 21'h0AAAA, 8'h20, 1'b0); out_a(1'b0, 1'b0, "R6 unlocked");

    // R8: odd, high-pair segment
    wr(1'b1, 21'h10AAAB, 8'hAA, 1'b0); out_b(1'b1, 1'b0, "R8 odd s1");
    wr(1'b1, 21'h105554, 8'h55, 1'b0); out_b(1'b1, 1'b0, "R8 even offset");
    wr(1'b1, 21'h10AAAB, 8'hA0, 1'b0); out_b(1'b1, 1'b0, "R8 no lock");
    wr(1'b1, 21'h10AAAB, 8'hAA, 1'b0);
    wr(1'b1, 21'h105555, 8'h55, 1'b0);
    wr(1'b1, 21'h10AAAB, 8'hA0, 1'b0); out_b(1'b1, 1'b1, "R8 odd lock");
    // R10
    chk(prot_a == 0, "R10 even untouched", prot_a, 0);
    wr(1'b1, 21'h10000, 8'h33, 1'b0); out_b(1'b1, 1'b1, "R8 odd window");
    end_pulse();
    wr(1'b1, 21'h0AAAB, 8'hAA, 1'b0); out_b(1'b0, 1'b1, "R8 low pair s1");
    wr(1'b1, 21'h05555, 8'h55, 1'b0);
    wr(1'b1, 21'h0AAAB, 8'hA0, 1'b0); out_b(1'b0, 1'b1, "R8 low pair s3");
    wr(1'b1, 21'h10010, 8'h34, 1'b0); out_b(1'b0, 1'b1, "R8 top bit matters");
    wr(1'b0, 21'h00600, 8'h99, 1'b0); out_a(1'b1, 1'b0, "R10 even passes");
    chk(pdata_b == 8'h33, "R10 odd forward held", pdata_b, 8'h33);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule